// File: doc/BRIEF.md
# Frame Difference Mean-Threshold Segmenter

This block splits a live video pixel stream into moving foreground and static background. It does this by comparing each live RGB pixel with a stored background pixel that arrives on the same cycle. For each colour component it takes the absolute difference of the two values. It then compares that difference with a threshold for the same component. The output is one mask bit per pixel: 1 marks foreground, 0 marks background.

The thresholds adapt. Each component's threshold is the mean absolute difference of that component over the previous whole frame. A frame-sync pulse marks the first pixel of each frame. While a frame streams in, the block sums the differences. When the next sync arrives, it divides the sum by the nominal pixel count, width times height, and the result becomes the new threshold. The division multiplies by a fixed reciprocal that gives the exact integer floor.

At reset every threshold takes a programmed starting value. The block is meant to sit between a frame-store reader, which supplies both streams, and the morphological filters that clean up the mask.

Top module: `motion_mask_seg`

## Requirements
- R1: Each component difference is the absolute value |live − background| for red (bits 23:16), green (bits 15:8) and blue (bits 7:0). The result does not depend on which of the two values is larger.
- R2: A component counts as foreground only when its difference is strictly greater than that component's current threshold. A difference equal to the threshold counts as background.
- R3: `maskBit` is 1 (foreground) when at least one component counts as foreground, and 0 (background) otherwise.
- R4: One pipeline register for the difference and one for the comparison put a pixel's result out exactly two clock cycles after it is presented. `maskValid` repeats `pixValid` two cycles late, and `maskBit` is 0 whenever `maskValid` is 0. After reset both outputs are 0.
- R5: A frame runs from a cycle with `frameSync` high up to the cycle before the next `frameSync`. At that next `frameSync`, each component's threshold becomes floor(sum of that component's differences over the frame's valid pixels / (FRAME_W·FRAME_H)). The new threshold already applies to the pixel that arrives with that sync.
- R6: Reset loads INIT_THRESH into all three thresholds. The first `frameSync` after reset keeps these values, because no complete frame has been summed yet.
- R7: A `frameSync` with `pixValid` low still starts a new frame. That frame's sum starts at zero, and the cycle produces no output pixel.
- R8: The accumulator holds (2^COMP_W − 1)·FRAME_W·FRAME_H without overflow. The reciprocal division gives the exact floor, so a frame of full-scale differences gives a threshold of full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | The live and background pixels on this cycle are valid |
| frameSync | input | 1 | One-cycle pulse marking the first cycle of a frame |
| livePix | input | 3·COMP_W | Live pixel, {R,G,B} |
| bgPix | input | 3·COMP_W | Background pixel, {R,G,B} |
| maskValid | output | 1 | `maskBit` carries a pixel result |
| maskBit | output | 1 | 1 = foreground, 0 = background |

## Verification
The bench builds the block with a 4×3 frame, which gives a pixel count of 12. Twelve is not a power of two, so the reciprocal multiply has to produce exact floors on sums that are not multiples of the count. The small frame also lets many threshold updates happen in a short run: the first-sync hold after reset, syncs that arrive without a pixel, frames with gaps in `pixValid`, and a frame of full-scale differences that drives the threshold to 255. The threshold values chosen for the stimulus set up pixel differences exactly equal to the threshold and one step either side of it.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int NUM_COMP = 3;

  // Strobes from the control unit to the datapath, all aligned to the
  // comparison stage.
  typedef struct packed {
    logic cmpValid;   // a pixel is in the comparison stage
    logic frameEdge;  // the pixel slot in that stage carries a frame sync
    logic loadMean;   // replace the threshold with the previous frame's mean
  } segStrobe_t;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixValid,
  input  logic       frameSync,
  output segStrobe_t strobe,
  output logic       maskValid
);

  logic validD1;
  logic syncD1;
  logic validD2;
  logic primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validD1 <= 1'b0;
      syncD1  <= 1'b0;
      validD2 <= 1'b0;
      primed  <= 1'b0;
    end else begin
      validD1 <= pixValid;
      syncD1  <= frameSync;
      validD2 <= validD1;
      if (syncD1) primed <= 1'b1;
    end
  end

  always_comb begin
    strobe.cmpValid  = validD1;
    strobe.frameEdge = syncD1;
    strobe.loadMean  = syncD1 & primed;
  end

  assign maskValid = validD2;

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int COMP_W      = 8,
  parameter int FRAME_W     = 1280,
  parameter int FRAME_H     = 1024,
  parameter int INIT_THRESH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pixValid,
  input  logic [NUM_COMP*COMP_W-1:0] livePix,
  input  logic [NUM_COMP*COMP_W-1:0] bgPix,
  input  segStrobe_t                 strobe,
  output logic                       maskBit
);

  localparam int PIX_N   = FRAME_W * FRAME_H;
  localparam int LOG_N   = $clog2(PIX_N);
  localparam int SUM_W   = COMP_W + LOG_N;
  localparam int SHIFT   = SUM_W + LOG_N;
  localparam int RECIP_W = SHIFT - LOG_N + 2;
  localparam int PROD_W  = SUM_W + RECIP_W;
  localparam logic [63:0] RECIP_WIDE =
    ((64'd1 << SHIFT) + 64'(PIX_N) - 64'd1) / 64'(PIX_N);
  localparam logic [RECIP_W-1:0] RECIP = RECIP_WIDE[RECIP_W-1:0];

  logic [NUM_COMP-1:0] compHit;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] liveC;
    logic [COMP_W-1:0] bgC;
    logic [COMP_W-1:0] diffReg;
    logic [SUM_W-1:0]  accReg;
    logic [COMP_W-1:0] thrReg;
    logic [PROD_W-1:0] prod;
    logic [COMP_W-1:0] meanC;
    logic [COMP_W-1:0] thrUse;

    assign liveC = livePix[c*COMP_W +: COMP_W];
    assign bgC   = bgPix[c*COMP_W +: COMP_W];

    // Stage 1: absolute difference
    always_ff @(posedge clk) begin
      if (!rstN) diffReg <= '0;
      else if (pixValid) diffReg <= (liveC >= bgC) ? (liveC - bgC) : (bgC - liveC);
    end

    // Exact floor division by the pixel count via reciprocal multiply
    assign prod   = PROD_W'(accReg) * PROD_W'(RECIP);
    assign meanC  = prod[SHIFT +: COMP_W];
    assign thrUse = strobe.loadMean ? meanC : thrReg;

    // Stage 2: threshold update and frame accumulation
    always_ff @(posedge clk) begin
      if (!rstN) begin
        thrReg <= COMP_W'(INIT_THRESH);
        accReg <= '0;
      end else if (strobe.frameEdge) begin
        thrReg <= thrUse;
        accReg <= strobe.cmpValid ? SUM_W'(diffReg) : '0;
      end else if (strobe.cmpValid) begin
        accReg <= accReg + SUM_W'(diffReg);
      end
    end

    assign compHit[c] = diffReg > thrUse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskBit <= 1'b0;
    else       maskBit <= strobe.cmpValid & (|compHit);
  end

endmodule

// File: rtl/motion_mask_seg.sv
module motion_mask_seg
  import seg_pkg::*;
#(
  parameter int COMP_W      = 8,
  parameter int FRAME_W     = 1280,
  parameter int FRAME_H     = 1024,
  parameter int INIT_THRESH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pixValid,
  input  logic                       frameSync,
  input  logic [NUM_COMP*COMP_W-1:0] livePix,
  input  logic [NUM_COMP*COMP_W-1:0] bgPix,
  output logic                       maskValid,
  output logic                       maskBit
);

  segStrobe_t strobe;

  seg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pixValid  (pixValid),
    .frameSync (frameSync),
    .strobe    (strobe),
    .maskValid (maskValid)
  );

  seg_datapath #(
    .COMP_W      (COMP_W),
    .FRAME_W     (FRAME_W),
    .FRAME_H     (FRAME_H),
    .INIT_THRESH (INIT_THRESH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pixValid (pixValid),
    .livePix  (livePix),
    .bgPix    (bgPix),
    .strobe   (strobe),
    .maskBit  (maskBit)
  );

endmodule

// File: rtl/seg_checker.sv
module seg_checker #(
  parameter int PIX_BITS = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                pixValid,
  input logic                frameSync,
  input logic [PIX_BITS-1:0] livePix,
  input logic [PIX_BITS-1:0] bgPix,
  input logic                maskValid,
  input logic                maskBit
);

  assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> ##1 maskValid);

  assert_no_bit_when_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !maskValid |-> !maskBit);

  assert_equal_pixels_background_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && (livePix == bgPix)) |=> ##1 !maskBit);

  assert_bare_sync_no_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !pixValid) |=> ##1 !maskValid);

endmodule

bind motion_mask_seg seg_checker #(.PIX_BITS(NUM_COMP*COMP_W)) u_seg_checker (
  .clk       (clk),
  .rstN      (rstN),
  .pixValid  (pixValid),
  .frameSync (frameSync),
  .livePix   (livePix),
  .bgPix     (bgPix),
  .maskValid (maskValid),
  .maskBit   (maskBit)
);

// File: tb/motion_mask_seg_tb.sv
module motion_mask_seg_tb;

  localparam int FW    = 4;
  localparam int FH    = 3;
  localparam int NPIX  = FW * FH;
  localparam int INITT = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic        frameSync = 1'b0;
  logic [23:0] livePix = '0;
  logic [23:0] bgPix = '0;
  logic        maskValid;
  logic        maskBit;

  int    compared = 0;
  int    mismatched = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string curReq = "R4";

  always #5 clk = ~clk;

  motion_mask_seg #(
    .COMP_W(8), .FRAME_W(FW), .FRAME_H(FH), .INIT_THRESH(INITT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameSync(frameSync),
    .livePix(livePix), .bgPix(bgPix), .maskValid(maskValid), .maskBit(maskBit)
  );

  // Behavioural reference model
  int thr[3];
  int acc[3];
  bit primed;
  bit e1V, e1M, e2V, e2M;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin thr[c] = INITT; acc[c] = 0; end
      primed = 0; e1V = 0; e1M = 0; e2V = 0; e2M = 0;
    end else begin
      bit m;
      m = 0;
      if (frameSync) begin
        for (int c = 0; c < 3; c++) begin
          if (primed) thr[c] = acc[c] / NPIX;
          acc[c] = 0;
        end
        primed = 1;
      end
      if (pixValid) begin
        for (int c = 0; c < 3; c++) begin
          int l, b, d;
          l = int'(livePix[c*8 +: 8]);
          b = int'(bgPix[c*8 +: 8]);
          d = (l > b) ? l - b : b - l;
          acc[c] += d;
          if (d > thr[c]) m = 1;
        end
      end
      e2V = e1V; e2M = e1M;
      e1V = pixValid; e1M = m;
    end
  end

  always @(negedge clk) begin
    if (checking && rstN && !done) begin
      compared++;
      if (maskValid !== e2V) begin
        mismatched++;
        $display("FAIL R4 maskValid actual=%0b expected=%0b at %0t", maskValid, e2V, $time);
      end
      compared++;
      if (maskBit !== (e2V & e2M)) begin
        mismatched++;
        $display("FAIL %s maskBit actual=%0b expected=%0b at %0t", curReq, maskBit, e2V & e2M, $time);
      end
    end
  end

  task automatic drive(input bit s, input bit v, input logic [23:0] l, input logic [23:0] b);
    @(negedge clk);
    frameSync = s; pixValid = v; livePix = l; bgPix = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, '0, '0);
  endtask

  // Frame whose every pixel has the given per-component differences
  task automatic flatFrame(input int dr, input int dg, input int db);
    for (int i = 0; i < NPIX; i++)
      drive(i == 0, 1, {8'(dr), 8'(dg), 8'(db)}, 24'h0);
  endtask

  task automatic randomFrame(input bit gaps);
    for (int i = 0; i < NPIX; i++) begin
      if (gaps && ($urandom % 3 == 0)) drive(0, 0, 24'($urandom), 24'($urandom));
      drive(i == 0, 1, 24'($urandom), 24'($urandom));
    end
  endtask

  initial begin
    // Reset state (R4)
    repeat (3) @(negedge clk);
    compared++;
    if (maskValid !== 1'b0 || maskBit !== 1'b0) begin
      mismatched++;
      $display("FAIL R4 reset outputs actual=%0b%0b expected=00", maskValid, maskBit);
    end
    rstN = 1'b1;
    checking = 1'b1;
    idle(2);

    // R6 / R2: first sync keeps INITT = 20; differences 19, 20, 21 on red
    curReq = "R6";
    drive(1, 1, {8'd20, 8'd0, 8'd0}, 24'h0);   // equal -> background
    drive(0, 1, {8'd21, 8'd0, 8'd0}, 24'h0);   // above -> foreground
    curReq = "R2";
    drive(0, 1, {8'd0, 8'd0, 8'd0}, {8'd19, 8'd20, 8'd20}); // all at/below -> background
    drive(0, 1, {8'd0, 8'd0, 8'd0}, {8'd0, 8'd0, 8'd21});   // blue above (R1 reversed order)
    for (int i = 4; i < NPIX; i++) drive(0, 1, 24'h0, 24'h0);
    idle(3);

    // R5: frame of known sums; mean not a whole multiple of 12
    curReq = "R5";
    for (int i = 0; i < NPIX; i++)
      drive(i == 0, 1, {8'(i * 7), 8'(100), 8'(3)}, 24'h0);  // red sum 462 -> 38
    for (int i = 0; i < NPIX; i++)
      drive(i == 0, 1, {8'(i * 8), 8'd99, 8'd4}, 24'h0);     // probes 38, 100, 3
    flatFrame(0, 0, 0);
    idle(2);

    // R1 / R3: random frames, some with gaps in pixValid
    curReq = "R3";
    for (int f = 0; f < 6; f++) randomFrame(f % 2 == 1);
    curReq = "R1";
    for (int i = 0; i < NPIX; i++)
      drive(i == 0, 1, 24'h000000, {8'(i * 20), 8'd5, 8'd250});
    idle(2);

    // R7: syncs without a pixel
    curReq = "R7";
    drive(1, 0, 24'hFFFFFF, 24'h0);
    for (int i = 0; i < NPIX; i++) drive(0, 1, {8'd40, 8'd0, 8'd0}, 24'h0);
    drive(1, 0, 24'h0, 24'h0);           // threshold red -> 40
    drive(0, 1, {8'd40, 8'd0, 8'd0}, 24'h0);
    drive(0, 1, {8'd41, 8'd0, 8'd0}, 24'h0);
    idle(3);

    // R8: full-scale frame drives the threshold to 255
    curReq = "R8";
    for (int i = 0; i < NPIX; i++) drive(i == 0, 1, 24'hFFFFFF, 24'h000000);
    for (int i = 0; i < NPIX; i++) drive(i == 0, 1, 24'h000000, 24'hFFFFFF);
    flatFrame(1, 1, 1);
    idle(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog run did not end actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule